// File: doc/BRIEF.md
# Battery Presence Detection Sequencer

This block decides whether a battery pack is connected to a charger output by running a timed two-phase test. In the first phase it enables a small discharge sink. At the end of that interval it samples a comparator flag that says whether the terminal voltage has collapsed below the short threshold. In the second phase it enables a wake source, which is meant to close an open pack protector. At the end of that interval it samples a flag that says whether the voltage has risen above the recharge threshold. A pack is reported absent only when both checks pass. Any other outcome reports that a new charge cycle should start.

The test is started in three ways: when power-on reset is released, when the battery voltage drops below the recharge threshold, or at the end of a short discharge pulse that follows charge termination. While no pack is found, the test repeats without pause. All interval timing is counted on a 1 ms tick input. Current magnitudes are analog and are not modelled. Only the enables, the interval timing and the decisions are.

Top module: `batt_detect_seq`

## Requirements
- R1: After reset, sink_en_o, wake_en_o, absent_pulse_o, start_chg_o and absent_o are all 0.
- R2: In idle with chg_en_i high, a 0-to-1 change of bat_below_rch_i starts the test, and so does a 1-to-0 change of por_i. sink_en_o is 1 after the next clock edge.
- R3: The discharge phase keeps sink_en_o high for exactly SINK_TICKS tick_i pulses. If bat_below_short_i is 1 on the final tick, the wake phase follows with wake_en_o high and sink_en_o low.
- R4: If bat_below_short_i is 0 on the final discharge tick, the block gives one start_chg_o pulse, clears absent_o and returns to idle with both enables low.
- R5: The wake phase keeps wake_en_o high for exactly WAKE_TICKS ticks. If bat_above_rch_i is 1 on the final tick, the block gives one absent_pulse_o pulse, sets absent_o, and restarts the discharge phase at once.
- R6: If bat_above_rch_i is 0 on the final wake tick, the block gives one start_chg_o pulse, clears absent_o and returns to idle.
- R7: sink_en_o and wake_en_o are never 1 together, and both are 0 in idle.
- R8: A term_det_i pulse in idle enables sink_en_o for TERM_TICKS ticks. If bat_below_rch_i is 1 on the last of those ticks, the discharge phase of the test follows directly. Otherwise the block returns to idle.
- R9: chg_en_i at 0 or por_i at 1 sends the block to idle at the next edge, drops both enables, and suppresses all results. A trigger seen while chg_en_i is 0 is ignored.
- R10: Each result pulse lasts one cycle. absent_o changes only with a result pulse, and is cleared by por_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| chg_en_i | input | 1 | Charging allowed; low aborts the test |
| por_i | input | 1 | Power-on reset level; high aborts, release triggers |
| term_det_i | input | 1 | Charge termination detected pulse |
| bat_below_rch_i | input | 1 | Battery voltage below recharge threshold |
| bat_below_short_i | input | 1 | Battery voltage below short threshold |
| bat_above_rch_i | input | 1 | Battery voltage above recharge threshold |
| sink_en_o | output | 1 | Discharge sink enable |
| wake_en_o | output | 1 | Wake source enable |
| absent_pulse_o | output | 1 | One-cycle result: no pack present |
| start_chg_o | output | 1 | One-cycle result: start a charge cycle |
| absent_o | output | 1 | Latched no-pack status |

## Verification
The bench builds the block with SINK_TICKS=4, WAKE_TICKS=3 and TERM_TICKS=2 in place of 1000, 500 and 262. With these values every phase boundary takes only a few ticks to reach, so each boundary can be checked one tick before and one tick after the end of the interval. Because the intervals are short, several full absent-repeat loops, the termination pulse leading into a test, and aborts during the discharge phase all fit in one short run. The lengths stay distinct, so a counter that uses the wrong interval length shows up as an enable edge at the wrong tick.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_WAKE  = 2'd2,
    ST_TDIS  = 2'd3
  } bpd_state_e;
endpackage

// File: rtl/bpd_trig.sv
module bpd_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rch_low_i,
  input  logic por_i,
  output logic rch_rise_o,
  output logic por_rel_o
);
  logic rch_q, por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rch_q <= 1'b0;
      por_q <= 1'b0;
    end else begin
      rch_q <= rch_low_i;
      por_q <= por_i;
    end
  end

  assign rch_rise_o = rch_low_i & ~rch_q;
  assign por_rel_o  = por_q & ~por_i;

  // R2
  trig_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_rel_o |-> $past(por_i));
endmodule

// File: rtl/bpd_interval.sv
module bpd_interval #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (done_o)      cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q < len_i));
endmodule

// File: rtl/bpd_fsm.sv
module bpd_fsm
  import bpd_pkg::*;
#(
  parameter int SINK_TICKS = 1000,
  parameter int WAKE_TICKS = 500,
  parameter int TERM_TICKS = 262,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_en_i,
  input  logic             por_i,
  input  logic             start_i,
  input  logic             term_det_i,
  input  logic             rch_low_i,
  input  logic             short_low_i,
  input  logic             rch_high_i,
  input  logic             done_i,
  output logic             clr_o,
  output logic [CNT_W-1:0] len_o,
  output logic             sink_en_o,
  output logic             wake_en_o,
  output logic             absent_pulse_o,
  output logic             start_pulse_o,
  output logic             absent_o
);
  bpd_state_e state_q, state_d;
  logic abort, absent_set, start_set;
  logic absent_q, apulse_q, spulse_q;

  assign abort = por_i | ~chg_en_i;

  always_comb begin
    state_d    = state_q;
    absent_set = 1'b0;
    start_set  = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i)         state_d = ST_DISCH;
          else if (term_det_i) state_d = ST_TDIS;
        end
        ST_DISCH: if (done_i) begin
          if (short_low_i) state_d = ST_WAKE;
          else begin
            state_d   = ST_IDLE;
            start_set = 1'b1;
          end
        end
        ST_WAKE: if (done_i) begin
          if (rch_high_i) begin
            state_d    = ST_DISCH;
            absent_set = 1'b1;
          end else begin
            state_d   = ST_IDLE;
            start_set = 1'b1;
          end
        end
        ST_TDIS: if (done_i) state_d = rch_low_i ? ST_DISCH : ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WAKE: len_o = CNT_W'(WAKE_TICKS);
      ST_TDIS: len_o = CNT_W'(TERM_TICKS);
      default: len_o = CNT_W'(SINK_TICKS);
    endcase
  end

  assign clr_o = (state_d != state_q) || (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      absent_q <= 1'b0;
      apulse_q <= 1'b0;
      spulse_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      apulse_q <= absent_set;
      spulse_q <= start_set;
      if (por_i)           absent_q <= 1'b0;
      else if (absent_set) absent_q <= 1'b1;
      else if (start_set)  absent_q <= 1'b0;
    end
  end

  assign sink_en_o      = (state_q == ST_DISCH) || (state_q == ST_TDIS);
  assign wake_en_o      = (state_q == ST_WAKE);
  assign absent_pulse_o = apulse_q;
  assign start_pulse_o  = spulse_q;
  assign absent_o       = absent_q;

  // R7
  enables_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sink_en_o && wake_en_o));
  // R3
  wake_after_sink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_en_o) |-> $past(sink_en_o));
  // R5
  absent_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_pulse_o |-> (absent_o && sink_en_o && !wake_en_o));
  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || !chg_en_i) |=> (!sink_en_o && !wake_en_o && !absent_pulse_o && !start_pulse_o));
  // R10
  apulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    absent_pulse_o |=> !absent_pulse_o);
  // R10
  spulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_pulse_o |=> !start_pulse_o);
  // R10
  absent_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(absent_o) |-> (absent_pulse_o || start_pulse_o || $past(por_i)));
endmodule

// File: rtl/batt_detect_seq.sv
module batt_detect_seq #(
  parameter int SINK_TICKS = 1000,
  parameter int WAKE_TICKS = 500,
  parameter int TERM_TICKS = 262
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic chg_en_i,
  input  logic por_i,
  input  logic term_det_i,
  input  logic bat_below_rch_i,
  input  logic bat_below_short_i,
  input  logic bat_above_rch_i,
  output logic sink_en_o,
  output logic wake_en_o,
  output logic absent_pulse_o,
  output logic start_chg_o,
  output logic absent_o
);
  localparam int MAX_AB    = (SINK_TICKS > WAKE_TICKS) ? SINK_TICKS : WAKE_TICKS;
  localparam int MAX_TICKS = (MAX_AB > TERM_TICKS) ? MAX_AB : TERM_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             rch_rise, por_rel, clr, done;
  logic [CNT_W-1:0] len;

  bpd_trig u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rch_low_i  (bat_below_rch_i),
    .por_i      (por_i),
    .rch_rise_o (rch_rise),
    .por_rel_o  (por_rel)
  );

  bpd_interval #(.CNT_W(CNT_W)) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick_i),
    .len_i  (len),
    .done_o (done)
  );

  bpd_fsm #(
    .SINK_TICKS (SINK_TICKS),
    .WAKE_TICKS (WAKE_TICKS),
    .TERM_TICKS (TERM_TICKS),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .chg_en_i       (chg_en_i),
    .por_i          (por_i),
    .start_i        (rch_rise | por_rel),
    .term_det_i     (term_det_i),
    .rch_low_i      (bat_below_rch_i),
    .short_low_i    (bat_below_short_i),
    .rch_high_i     (bat_above_rch_i),
    .done_i         (done),
    .clr_o          (clr),
    .len_o          (len),
    .sink_en_o      (sink_en_o),
    .wake_en_o      (wake_en_o),
    .absent_pulse_o (absent_pulse_o),
    .start_pulse_o  (start_chg_o),
    .absent_o       (absent_o)
  );
endmodule

// File: tb/batt_detect_seq_bench.sv
module batt_detect_seq_bench;
  localparam int CLK_P = 10;
  localparam int SINK  = 4;
  localparam int WAKE  = 3;
  localparam int TERM  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, chg_en = 1, por = 0, term = 0;
  logic below_rch = 0, below_short = 0, above_rch = 0;
  logic sink_en, wake_en, absent_p, start_p, absent;

  int total = 0, bad = 0;
  string exp_kind[$];
  string exp_req[$];

  always #(CLK_P/2) clk = ~clk;

  batt_detect_seq #(.SINK_TICKS(SINK), .WAKE_TICKS(WAKE), .TERM_TICKS(TERM)) u_batt_detect_seq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .chg_en_i(chg_en), .por_i(por),
    .term_det_i(term), .bat_below_rch_i(below_rch), .bat_below_short_i(below_short),
    .bat_above_rch_i(above_rch), .sink_en_o(sink_en), .wake_en_o(wake_en),
    .absent_pulse_o(absent_p), .start_chg_o(start_p), .absent_o(absent));

  task automatic chk(string req, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  task automatic push(string kind, string req);
    exp_kind.push_back(kind);
    exp_req.push_back(req);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic rch_drop();
    @(negedge clk) below_rch = 1'b0;
    @(negedge clk) below_rch = 1'b1;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (absent_p || start_p)) begin
      string got_k;
      got_k = absent_p ? "ABSENT" : "START";
      total++;
      if (absent_p && start_p) begin
        bad++;
        $display("FAIL R10 both results at once: got=ABSENT+START exp=one");
      end else if (exp_kind.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected result: got=%s exp=none", got_k);
      end else begin
        string ek, er;
        ek = exp_kind.pop_front();
        er = exp_req.pop_front();
        if (ek != got_k) begin
          bad++;
          $display("FAIL %s result: got=%s exp=%s", er, got_k, ek);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "sink", sink_en, 0); chk("R1", "wake", wake_en, 0);
    chk("R1", "absent_p", absent_p, 0); chk("R1", "start_p", start_p, 0);
    chk("R1", "absent", absent, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "idle sink", sink_en, 0); chk("R7", "idle wake", wake_en, 0);

    // absent round then failing discharge round
    rch_drop();
    chk("R2", "sink after rch drop", sink_en, 1);
    below_short = 1; above_rch = 1;
    tick_n(SINK - 1);
    chk("R3", "sink before end", sink_en, 1); chk("R3", "wake before end", wake_en, 0);
    tick_n(1);
    chk("R3", "wake after discharge", wake_en, 1); chk("R7", "sink in wake", sink_en, 0);
    push("ABSENT", "R5");
    tick_n(WAKE - 1);
    chk("R5", "wake before end", wake_en, 1);
    tick_n(1);
    chk("R5", "absent latched", absent, 1); chk("R5", "restart sink", sink_en, 1);
    chk("R5", "wake off on restart", wake_en, 0);
    below_short = 0;
    push("START", "R4");
    tick_n(SINK);
    chk("R4", "idle sink", sink_en, 0); chk("R4", "idle wake", wake_en, 0);
    chk("R4", "absent cleared", absent, 0);

    // wake phase fails
    rch_drop();
    below_short = 1; above_rch = 0;
    tick_n(SINK);
    chk("R3", "wake entered", wake_en, 1);
    push("START", "R6");
    tick_n(WAKE);
    chk("R6", "idle sink", sink_en, 0); chk("R6", "idle wake", wake_en, 0);
    chk("R6", "absent", absent, 0);

    // termination pulse leading into test
    @(negedge clk) below_rch = 0;
    @(negedge clk) term = 1;
    @(negedge clk) term = 0;
    chk("R8", "term sink", sink_en, 1);
    below_rch = 1;
    tick_n(TERM - 1);
    chk("R8", "term sink held", sink_en, 1); chk("R8", "term wake", wake_en, 0);
    tick_n(1);
    chk("R8", "into discharge", sink_en, 1);
    tick_n(SINK - 1);
    chk("R8", "discharge length", wake_en, 0);
    tick_n(1);
    chk("R8", "wake after term test", wake_en, 1);
    push("START", "R6");
    tick_n(WAKE);
    // termination with voltage above threshold
    @(negedge clk) below_rch = 0;
    @(negedge clk) term = 1;
    @(negedge clk) term = 0;
    tick_n(TERM);
    chk("R8", "term back to idle", sink_en, 0);
    tick_n(SINK);
    chk("R8", "no test started", wake_en, 0);

    // abort keeps absent latched
    rch_drop();
    above_rch = 1;
    tick_n(SINK);
    push("ABSENT", "R5");
    tick_n(WAKE);
    chk("R5", "absent set", absent, 1);
    tick_n(1);
    @(negedge clk) chg_en = 0;
    @(negedge clk);
    chk("R9", "sink dropped", sink_en, 0); chk("R9", "wake dropped", wake_en, 0);
    chk("R10", "absent held on abort", absent, 1);
    rch_drop();
    chk("R9", "trigger ignored", sink_en, 0);
    tick_n(SINK + WAKE);
    chk("R9", "still idle", sink_en, 0);
    chg_en = 1;

    // por clears and release triggers
    @(negedge clk) por = 1;
    @(negedge clk) por = 0;
    chk("R10", "por clears absent", absent, 0);
    chk("R9", "por idle", sink_en, 0);
    @(negedge clk);
    chk("R2", "por release starts", sink_en, 1);
    below_short = 0;
    push("START", "R4");
    tick_n(SINK);
    chk("R4", "idle after por test", sink_en, 0);
    repeat (4) @(negedge clk);

    total++;
    if (exp_kind.size() != 0) begin
      bad++;
      $display("FAIL R10 missing results: got=%0d pending exp=0", exp_kind.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule